// File: doc/BRIEF.md
# Byte-Byte-Jump Serial Control Sequencer

This block produces the endless, data-independent control waveform that turns a serial SRAM plus a serial system-bus peripheral, both sharing one bidirectional data line, into a byte-byte-jump processor. Every instruction is split into three phases. The fetch phase copies the 48-bit instruction addressed by the pointer at SRAM address 0 back over the pointer. The source phase moves one byte from the system into a scratch byte at SRAM address 6. The store phase streams the destination address and that byte out to the system. The block never looks at data. It only frames commands, drives addresses and one-bit system tags, and releases the line whenever another device must talk.

Four outputs leave the block: two active-low selects, a line-drive enable, and a line-drive value. All state advances on the falling edge of the serial clock, so every output is settled well before the rising edge at which the SRAM and the system sample. A synchronous reset, also taken on the falling edge, parks the outputs and restarts the sequence at the first fetch step.

Top module: `bbj_ctrl_seq`

## Requirements
- R1: While reset is high at a falling edge, both selects are 1 and the drive enable and value are 0 after that edge. The first falling edge with reset low starts the first fetch step, and a reset in mid-sequence restarts from that step.
- R2: One instruction lasts exactly 240 clocks, and the waveform repeats identically for each following instruction.
- R3: Fetch phase: 1 clock with the system select alone low, driving 0. Then, with both selects low, the 24-bit frame 0x030000 is driven, the line is released for 16 clocks, the SRAM select goes high for 1 clock, the frame 0x020000 is driven, and the line is released for 48 clocks.
- R4: Source phase: the same framing as R3, with tag 0, read frame 0x030002, a 16-clock release, write frame 0x020006, and an 8-clock release.
- R5: Store phase: tag 1 with the system select alone low, then the read frame 0x030004 with both selects low, then a 24-clock release.
- R6: Each frame is an 8-bit command followed by a 16-bit address, sent most significant bit first, one bit per clock.
- R7: Each phase ends with one clock in which both selects are high. Inside the fetch and source phases, the SRAM select is high for exactly one clock between its read and write frames while the system select stays low.
- R8: Whenever the drive enable is 0, the drive value is 0. The drive enable is 0 whenever both selects are high.
- R9: Outputs change only on falling clock edges and hold steady across each rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; state advances on its falling edge |
| rst | input | 1 | Synchronous reset, active high, sampled on the falling edge |
| sramSelN | output | 1 | SRAM select, active low |
| sysSelN | output | 1 | System-bus select, active low |
| lineDriveEn | output | 1 | 1 when the sequencer drives the shared data line |
| lineDriveVal | output | 1 | Bit driven on the shared line; 0 when not driving |

## Verification
Every output is due at the falling edge that opens its clock slot, one register stage after the state update, and it is read at the next rising edge, where the peripherals sample it. The bench samples each slot twice: once shortly after the falling edge and once just after the rising edge. It compares the two samples to check stability, then compares the rising-edge sample with the expected slot from a segment table. After a reset, the first slot becomes due at the first falling edge with reset low, so the walk starts counting at that edge.

// File: rtl/bbj_seq_pkg.sv
package bbj_seq_pkg;

  // Strobes from the control to the frame shifter.
  typedef struct packed {
    logic load;   // take a new frame word
    logic shift;  // advance one bit toward the MSB
  } seqStrobeT;

endpackage

// File: rtl/bbj_seq_ctrl.sv
module bbj_seq_ctrl
  import bbj_seq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int CMD_W     = 8,
  parameter int PTR_ADDR  = 0,
  parameter int SRC_PTR   = 2,
  parameter int DST_PTR   = 4,
  parameter int VAL_ADDR  = 6,
  parameter int CMD_READ  = 3,
  parameter int CMD_WRITE = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  output seqStrobeT                strobe,
  output logic [CMD_W+ADDR_W-1:0]  word,
  output logic                     sramSelN,
  output logic                     sysSelN,
  output logic                     driveEn
);

  localparam int FRAME_W   = CMD_W + ADDR_W;
  localparam int INSN_BITS = 3 * ADDR_W;
  localparam int MAX_LEN   = (INSN_BITS > FRAME_W) ? INSN_BITS : FRAME_W;
  localparam int CNT_W     = $clog2(MAX_LEN + 1);
  localparam int STEPS     = 18;
  localparam int STEP_W    = $clog2(STEPS);

  typedef struct packed {
    logic [CNT_W-1:0]   len;      // slot count minus one
    logic               sramLow;
    logic               sysLow;
    logic               drive;
    logic [FRAME_W-1:0] word;
  } stepT;

  function automatic stepT mk(input int len, input logic s, input logic y,
                              input logic d, input logic [FRAME_W-1:0] w);
    stepT r;
    r.len     = CNT_W'(len - 1);
    r.sramLow = s;
    r.sysLow  = y;
    r.drive   = d;
    r.word    = w;
    return r;
  endfunction

  function automatic logic [FRAME_W-1:0] frame(input int cmd, input int addr);
    return {CMD_W'(cmd), ADDR_W'(addr)};
  endfunction

  // The fixed program of one instruction.
  function automatic stepT stepInfo(input logic [STEP_W-1:0] idx);
    logic [FRAME_W-1:0] zero;
    logic [FRAME_W-1:0] tagOne;
    zero   = '0;
    tagOne = {1'b1, {(FRAME_W-1){1'b0}}};
    case (idx)
      // fetch
      5'd0:    return mk(1,              1'b0, 1'b1, 1'b1, zero);
      5'd1:    return mk(FRAME_W,        1'b1, 1'b1, 1'b1, frame(CMD_READ, PTR_ADDR));
      5'd2:    return mk(ADDR_W,         1'b1, 1'b1, 1'b0, zero);
      5'd3:    return mk(1,              1'b0, 1'b1, 1'b0, zero);
      5'd4:    return mk(FRAME_W,        1'b1, 1'b1, 1'b1, frame(CMD_WRITE, PTR_ADDR));
      5'd5:    return mk(INSN_BITS,      1'b1, 1'b1, 1'b0, zero);
      5'd6:    return mk(1,              1'b0, 1'b0, 1'b0, zero);
      // source
      5'd7:    return mk(1,              1'b0, 1'b1, 1'b1, zero);
      5'd8:    return mk(FRAME_W,        1'b1, 1'b1, 1'b1, frame(CMD_READ, SRC_PTR));
      5'd9:    return mk(ADDR_W,         1'b1, 1'b1, 1'b0, zero);
      5'd10:   return mk(1,              1'b0, 1'b1, 1'b0, zero);
      5'd11:   return mk(FRAME_W,        1'b1, 1'b1, 1'b1, frame(CMD_WRITE, VAL_ADDR));
      5'd12:   return mk(DATA_W,         1'b1, 1'b1, 1'b0, zero);
      5'd13:   return mk(1,              1'b0, 1'b0, 1'b0, zero);
      // store
      5'd14:   return mk(1,              1'b0, 1'b1, 1'b1, tagOne);
      5'd15:   return mk(FRAME_W,        1'b1, 1'b1, 1'b1, frame(CMD_READ, DST_PTR));
      5'd16:   return mk(ADDR_W + DATA_W, 1'b1, 1'b1, 1'b0, zero);
      default: return mk(1,              1'b0, 1'b0, 1'b0, zero);
    endcase
  endfunction

  logic               active;
  logic [STEP_W-1:0]  step;
  logic [CNT_W-1:0]   cnt;
  logic [STEP_W-1:0]  nxtIdx;
  stepT               nxtInfo;

  always_comb begin
    if (!active || step == STEP_W'(STEPS - 1)) nxtIdx = '0;
    else                                       nxtIdx = step + 1'b1;
    nxtInfo      = stepInfo(nxtIdx);
    strobe.load  = !active || (cnt == '0);
    strobe.shift = active && (cnt != '0);
    word         = nxtInfo.word;
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      step     <= '0;
      cnt      <= '0;
      sramSelN <= 1'b1;
      sysSelN  <= 1'b1;
      driveEn  <= 1'b0;
    end else if (strobe.load) begin
      active   <= 1'b1;
      step     <= nxtIdx;
      cnt      <= nxtInfo.len;
      sramSelN <= !nxtInfo.sramLow;
      sysSelN  <= !nxtInfo.sysLow;
      driveEn  <= nxtInfo.drive;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_STEP_RANGE: assert property (@(negedge clk) disable iff (rst)
    step < STEP_W'(STEPS)) else $error("step out of range"); // R2
  AST_DRIVE_HAS_LISTENER: assert property (@(negedge clk) disable iff (rst)
    driveEn |-> !sysSelN) else $error("driving with system deselected"); // R8
  AST_GAP_UNDRIVEN: assert property (@(negedge clk) disable iff (rst)
    (sramSelN && sysSelN) |-> !driveEn) else $error("line driven in gap"); // R8
  AST_SRAM_REENTRY: assert property (@(negedge clk) disable iff (rst)
    ($rose(sramSelN) && !sysSelN) |=> !sramSelN) else $error("SRAM gap too long"); // R7
  AST_SYS_GAP_ONE: assert property (@(negedge clk) disable iff (rst)
    $rose(sysSelN) |=> !sysSelN) else $error("system gap too long"); // R7

endmodule

// File: rtl/bbj_seq_dpath.sv
module bbj_seq_dpath
  import bbj_seq_pkg::*;
#(
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobeT          strobe,
  input  logic [FRAME_W-1:0] word,
  input  logic               driveEn,
  output logic               lineDriveVal
);

  logic [FRAME_W-1:0] shiftReg;

  always_ff @(negedge clk) begin
    if (rst)               shiftReg <= '0;
    else if (strobe.load)  shiftReg <= word;
    else if (strobe.shift) shiftReg <= shiftReg << 1;
  end

  assign lineDriveVal = driveEn & shiftReg[FRAME_W-1];

  AST_SHIFT_MSB: assert property (@(negedge clk) disable iff (rst)
    strobe.shift |=> shiftReg == ($past(shiftReg) << 1)) else $error("shift order"); // R6
  AST_VALUE_QUIET: assert property (@(negedge clk) disable iff (rst)
    !driveEn |-> !lineDriveVal) else $error("value while released"); // R8

endmodule

// File: rtl/bbj_ctrl_seq.sv
module bbj_ctrl_seq
  import bbj_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CMD_W  = 8
) (
  input  logic clk,
  input  logic rst,
  output logic sramSelN,
  output logic sysSelN,
  output logic lineDriveEn,
  output logic lineDriveVal
);

  localparam int FRAME_W = CMD_W + ADDR_W;

  seqStrobeT          strobe;
  logic [FRAME_W-1:0] word;

  bbj_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMD_W(CMD_W)) ctrl_i (
    .clk(clk), .rst(rst), .strobe(strobe), .word(word),
    .sramSelN(sramSelN), .sysSelN(sysSelN), .driveEn(lineDriveEn)
  );

  bbj_seq_dpath #(.FRAME_W(FRAME_W)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .word(word),
    .driveEn(lineDriveEn), .lineDriveVal(lineDriveVal)
  );

endmodule

// File: tb/bbj_ctrl_seq_tb.sv
module bbj_ctrl_seq_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sramSelN, sysSelN, lineDriveEn, lineDriveVal;
  int   errs = 0;
  int   checks = 0;
  int   segIdx = 0;
  int   bitIdx = 0;

  always #4 clk = ~clk;

  bbj_ctrl_seq dut_i (
    .clk(clk), .rst(rst), .sramSelN(sramSelN), .sysSelN(sysSelN),
    .lineDriveEn(lineDriveEn), .lineDriveVal(lineDriveVal)
  );

  // {len, sramN, sysN, en, req, frame}
  localparam int NSEG = 18;
  localparam logic [42:0] SEG [NSEG] = '{
    {8'd1,  1'b1, 1'b0, 1'b1, 8'd3, 24'h000000},  // R3 tag 0
    {8'd24, 1'b0, 1'b0, 1'b1, 8'd3, 24'h030000},  // R3 read pointer
    {8'd16, 1'b0, 1'b0, 1'b0, 8'd3, 24'h000000},  // R3 release
    {8'd1,  1'b1, 1'b0, 1'b0, 8'd7, 24'h000000},  // R7 SRAM gap
    {8'd24, 1'b0, 1'b0, 1'b1, 8'd3, 24'h020000},  // R3 write pointer
    {8'd48, 1'b0, 1'b0, 1'b0, 8'd3, 24'h000000},  // R3 instruction
    {8'd1,  1'b1, 1'b1, 1'b0, 8'd7, 24'h000000},  // R7 phase gap
    {8'd1,  1'b1, 1'b0, 1'b1, 8'd4, 24'h000000},  // R4 tag 0
    {8'd24, 1'b0, 1'b0, 1'b1, 8'd4, 24'h030002},  // R4 read source ptr
    {8'd16, 1'b0, 1'b0, 1'b0, 8'd4, 24'h000000},  // R4 release
    {8'd1,  1'b1, 1'b0, 1'b0, 8'd7, 24'h000000},  // R7 SRAM gap
    {8'd24, 1'b0, 1'b0, 1'b1, 8'd4, 24'h020006},  // R4 write value
    {8'd8,  1'b0, 1'b0, 1'b0, 8'd4, 24'h000000},  // R4 byte
    {8'd1,  1'b1, 1'b1, 1'b0, 8'd7, 24'h000000},  // R7 phase gap
    {8'd1,  1'b1, 1'b0, 1'b1, 8'd5, 24'h800000},  // R5 tag 1
    {8'd24, 1'b0, 1'b0, 1'b1, 8'd5, 24'h030004},  // R5 read dest ptr
    {8'd24, 1'b0, 1'b0, 1'b0, 8'd5, 24'h000000},  // R5 stream out
    {8'd1,  1'b1, 1'b1, 1'b0, 8'd7, 24'h000000}   // R7 phase gap
  };

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // One slot: sample after the falling edge and just after the rising edge.
  task automatic walkCycles(input int n, input bit second);
    for (int i = 0; i < n; i++) begin
      logic [3:0] early, late, exp;
      logic [42:0] s;
      logic vExp;
      string tag;
      @(negedge clk); #2;
      early = {sramSelN, sysSelN, lineDriveEn, lineDriveVal};
      @(posedge clk); #1;
      late  = {sramSelN, sysSelN, lineDriveEn, lineDriveVal};
      check("R9 stable across rise", late, early);
      s    = SEG[segIdx];
      vExp = s[32] ? s[23 - bitIdx] : 1'b0;  // R6 MSB first, R8 zero when released
      tag  = $sformatf("R%0d%s", s[31:24], second ? " (R2 repeat)" : "");
      check(tag, late[3:1], {s[34], s[33], s[32]});
      check(s[32] ? "R6 frame bit" : "R8 released value", {3'b0, late[0]}, {3'b0, vExp});
      bitIdx++;
      if (bitIdx == int'(s[42:35])) begin
        bitIdx = 0;
        segIdx = (segIdx + 1) % NSEG;
      end
    end
  endtask

  initial begin
    int total;
    total = 0;
    for (int k = 0; k < NSEG; k++) total += int'(SEG[k][42:35]);
    checks++;
    if (total != 240) begin errs++; $display("FAIL R2: table %0d expected 240", total); end

    // R1 reset state
    repeat (3) @(posedge clk);
    #1 check("R1 reset outputs", {sramSelN, sysSelN, lineDriveEn, lineDriveVal}, 4'b1100);
    rst = 1'b0;
    walkCycles(240, 1'b0);
    walkCycles(240, 1'b1);  // R2 second instruction identical
    walkCycles(37, 1'b0);

    // R1 mid-sequence reset
    rst = 1'b1;
    repeat (2) begin
      @(negedge clk); #2;
      check("R1 reset mid-run", {sramSelN, sysSelN, lineDriveEn, lineDriveVal}, 4'b1100);
    end
    @(posedge clk); #1;
    rst = 1'b0;
    segIdx = 0; bitIdx = 0;
    walkCycles(60, 1'b0);  // R1 restart at first fetch step

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1600000;
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule